// File: doc/BRIEF.md
# Four-Channel Prescaled Down-Counter Unit

This block holds four independent down-counters behind a simple synchronous register port, plus one shared interrupt bank. Each counter has its own prescaler (divide by 1, 16 or 256) and a control word. The control word picks the counter width (16 or 32 bits) and what happens when the counter wraps: stop (one-shot), reload a stored value (periodic), or roll to all-ones (free-running).

Software loads a count, sets the control word and then waits for the interrupt line. A second reload register can be written while a counter runs. It changes the reload value without disturbing the running count, so the new period starts cleanly at the next wrap. Each counter has a raw status bit. A mask register gates these bits onto one interrupt output, and a write-one-to-clear register acknowledges them.

Top module: `quad_timer_unit`

## Requirements
- R1: After reset every readable register reads zero, `reg_rdata` is zero and `irq_o` is low.
- R2: The address map is fixed. Bits [1:0] of the address are ignored.
  - Shared registers: mask at 0x00, raw status at 0x04, masked status at 0x08, clear at 0x0C.
  - Counter n (n = 0..3) starts at base 0x10 + 0x10·n: load at +0x0, current value at +0x4, control at +0x8, background reload at +0xC.
  - A read returns the register as it stood in the read cycle, on `reg_rdata` from the next cycle. `reg_rdata` holds that value until the next read.
  - The clear register and unmapped addresses read zero. Writes to unmapped addresses change nothing.
- R3: Control word fields:
  - bit 7 is run;
  - bit 6 selects periodic (1) or free-running (0);
  - bits 3:2 are the divider select;
  - bit 1 selects 32-bit width;
  - bit 0 selects one-shot.
  Other bits are not stored and read zero.
- R4: The divider select works as follows: bit 3 set gives one tick per 256 enabled cycles; otherwise bit 2 set gives one per 16; otherwise every enabled cycle ticks. A write to the control register restarts the divider phase.
- R5: Each tick decrements the count by one. A tick that finds the count at zero is a wrap, and it sets raw status bit n.
- R6: On a wrap in periodic mode (one-shot clear), the count becomes the stored reload value.
- R7: On a wrap in free-running mode (one-shot clear), the count becomes all-ones of the selected width (0xFFFF or 0xFFFFFFFF).
- R8: On a wrap in one-shot mode, the count stays at zero and the run bit clears. One-shot takes precedence over periodic.
- R9: Reload registers:
  - A load write sets both the count and the reload value. It overrides a tick in the same cycle, so that cycle produces no wrap.
  - A background write sets only the reload value. The count is unchanged until the next wrap.
  - Both the load and background addresses read back the reload value.
- R10: In 16-bit mode only the low 16 bits of the count are used. Reads of the current value return zero in bits 31:16.
- R11: Writing 1 to bit n of the clear register clears raw bit n, and 0 bits have no effect. A wrap in the same cycle wins over the clear.
- R12: Masked status is raw AND mask (bits 3:0). `irq_o` is the OR of the masked bits, registered one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined masked interrupt, registered |

## Verification
A wrong count or reload state shows up on the next read of the current-value register. A faulty divider or wrap decision shows up one cycle after the faulty tick, as a bad value or an early or late raw bit. Once a raw or mask bit is wrong, `irq_o` is wrong on the following cycle. The bench therefore compares `irq_o` on every cycle and every read against a cycle model, so a fault is reported within a few cycles of its first visible effect.

// File: rtl/qtu_pkg.sv
package qtu_pkg;
  typedef struct packed {
    logic       run;
    logic       reload_mode;
    logic [1:0] div_sel;
    logic       wide;
    logic       single;
  } qtu_ctrl_t;

  localparam logic [1:0] SLOT_LOAD  = 2'd0;
  localparam logic [1:0] SLOT_VALUE = 2'd1;
  localparam logic [1:0] SLOT_CTRL  = 2'd2;
  localparam logic [1:0] SLOT_BG    = 2'd3;

  function automatic qtu_ctrl_t word_to_ctrl(input logic [7:0] w);
    qtu_ctrl_t c;
    c.run         = w[7];
    c.reload_mode = w[6];
    c.div_sel     = w[3:2];
    c.wide        = w[1];
    c.single      = w[0];
    return c;
  endfunction

  function automatic logic [7:0] ctrl_to_word(input qtu_ctrl_t c);
    return {c.run, c.reload_mode, 2'b00, c.div_sel, c.wide, c.single};
  endfunction
endpackage

// File: rtl/qtu_prescale.sv
module qtu_prescale #(
  parameter int PSW = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int MIDW = 4;
  logic [PSW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else if (run)       pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    if (!run)           tick = 1'b0;
    else if (div_sel[1]) tick = &pre_q;
    else if (div_sel[0]) tick = &pre_q[MIDW-1:0];
    else                tick = 1'b1;
  end
endmodule

// File: rtl/qtu_channel.sv
module qtu_channel
  import qtu_pkg::*;
#(
  parameter int DW  = 32,
  parameter int PSW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic          bg_we,
  input  logic          ctl_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] reload_o,
  output logic [7:0]    ctrl_o,
  output logic          ev_o
);
  localparam int HW = DW / 2;

  qtu_ctrl_t     ctl_q;
  logic [DW-1:0] cnt_q, rel_q, cur;
  logic          tick;

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input logic wide);
    return wide ? v : {{(DW-HW){1'b0}}, v[HW-1:0]};
  endfunction

  qtu_prescale #(.PSW(PSW)) u_pre (
    .clk(clk), .rst(rst), .run(ctl_q.run), .restart(ctl_we),
    .div_sel(ctl_q.div_sel), .tick(tick)
  );

  assign cur  = fit(cnt_q, ctl_q.wide);
  assign ev_o = tick && (cur == '0) && !ld_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      cnt_q <= '0;
      rel_q <= '0;
    end else begin
      if (ctl_we)                   ctl_q     <= word_to_ctrl(wdata[7:0]);
      else if (ev_o && ctl_q.single) ctl_q.run <= 1'b0;

      if (ld_we || bg_we) rel_q <= wdata;

      if (ld_we)
        cnt_q <= fit(wdata, ctl_q.wide);
      else if (tick) begin
        if (cur != '0)             cnt_q <= fit(cur - 1'b1, ctl_q.wide);
        else if (ctl_q.single)      cnt_q <= '0;
        else if (ctl_q.reload_mode) cnt_q <= fit(rel_q, ctl_q.wide);
        else                        cnt_q <= fit('1, ctl_q.wide);
      end
    end
  end

  assign cnt_o    = cur;
  assign reload_o = rel_q;
  assign ctrl_o   = ctrl_to_word(ctl_q);

  // R5
  dec_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && ctl_q.wide && cur != '0 && !ld_we) |=> cnt_q == $past(cnt_q) - 1'b1)
    else $error("dec_chk");

  // R8
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_o && ctl_q.single && !ctl_we) |=> !ctl_q.run)
    else $error("oneshot_stop_chk");

  // R10
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !ctl_q.wide && !ld_we) |=> cnt_q[DW-1:HW] == '0)
    else $error("narrow_upper_chk");

  // R9
  bg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bg_we && !ld_we && !tick) |=> $stable(cnt_q))
    else $error("bg_hold_chk");
endmodule

// File: rtl/qtu_irq.sv
module qtu_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mask_we,
  input  logic           clr_we,
  input  logic [NCH-1:0] wbits,
  input  logic [NCH-1:0] ev,
  output logic [NCH-1:0] mask_o,
  output logic [NCH-1:0] raw_o,
  output logic           irq_o
);
  logic [NCH-1:0] mask_q, raw_q, clr_bits;
  logic           irq_q;

  assign clr_bits = clr_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      raw_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wbits;
      raw_q <= (raw_q & ~clr_bits) | ev;
      irq_q <= |(raw_q & mask_q);
    end
  end

  assign mask_o = mask_q;
  assign raw_o  = raw_q;
  assign irq_o  = irq_q;

  // R12
  irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == $past(|(raw_q & mask_q)))
    else $error("irq_lag_chk");

  // R11
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> (raw_q & $past(wbits & ~ev)) == '0)
    else $error("clr_chk");

  // R5
  raw_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> (raw_q & $past(ev)) == $past(ev))
    else $error("raw_set_chk");
endmodule

// File: rtl/quad_timer_unit.sv
module quad_timer_unit
  import qtu_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8,
  parameter int PSW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);
  localparam int BW = AW - 4;

  logic [BW-1:0]  blk;
  logic [1:0]     slot;
  logic [DW-1:0]  cnt_a [NCH];
  logic [DW-1:0]  rel_a [NCH];
  logic [7:0]     ctl_a [NCH];
  logic [NCH-1:0] ev, mask_v, raw_v;
  logic [DW-1:0]  rmux, rdata_q;

  assign blk  = reg_addr[AW-1:4];
  assign slot = reg_addr[3:2];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = reg_we && (blk == BW'(i + 1));
    qtu_channel #(.DW(DW), .PSW(PSW)) u_ch (
      .clk(clk), .rst(rst),
      .ld_we(hit && slot == SLOT_LOAD),
      .bg_we(hit && slot == SLOT_BG),
      .ctl_we(hit && slot == SLOT_CTRL),
      .wdata(reg_wdata),
      .cnt_o(cnt_a[i]), .reload_o(rel_a[i]), .ctrl_o(ctl_a[i]), .ev_o(ev[i])
    );
  end

  qtu_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst(rst),
    .mask_we(reg_we && blk == '0 && slot == 2'd0),
    .clr_we(reg_we && blk == '0 && slot == 2'd3),
    .wbits(reg_wdata[NCH-1:0]), .ev(ev),
    .mask_o(mask_v), .raw_o(raw_v), .irq_o(irq_o)
  );

  always_comb begin
    rmux = '0;
    if (blk == '0) begin
      case (slot)
        2'd0:    rmux = DW'(mask_v);
        2'd1:    rmux = DW'(raw_v);
        2'd2:    rmux = DW'(raw_v & mask_v);
        default: rmux = '0;
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      if (blk == BW'(i + 1)) begin
        case (slot)
          SLOT_VALUE: rmux = cnt_a[i];
          SLOT_CTRL:  rmux = DW'(ctl_a[i]);
          default:    rmux = rel_a[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_re) rdata_q <= rmux;
  end

  assign reg_rdata = rdata_q;

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_re |=> $stable(reg_rdata))
    else $error("rdata_hold_chk");
endmodule

// File: tb/quad_timer_unit_bench.sv
module quad_timer_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int errors = 0, checks = 0;
  bit live = 1'b0;

  always #4 clk = ~clk;

  quad_timer_unit u_quad_timer_unit (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // cycle model built from the requirements
  logic [31:0] m_cnt [4];
  logic [31:0] m_rel [4];
  logic [7:0]  m_ctl [4];
  logic [7:0]  m_pre [4];
  logic [3:0]  m_raw, m_mask;
  logic        m_irq;
  logic [31:0] m_rdata;

  function automatic logic [31:0] fit(input logic [31:0] v, input logic w);
    return w ? v : {16'h0, v[15:0]};
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int b = int'(a[7:4]);
    case (b)
      0: case (a[3:2])
           2'd0: return {28'h0, m_mask};
           2'd1: return {28'h0, m_raw};
           2'd2: return {28'h0, m_raw & m_mask};
           default: return 32'h0;
         endcase
      1, 2, 3, 4: case (a[3:2])
           2'd1: return fit(m_cnt[b-1], m_ctl[b-1][1]);
           2'd2: return {24'h0, m_ctl[b-1]};
           default: return m_rel[b-1];
         endcase
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [3:0] evv;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_cnt[i] = '0; m_rel[i] = '0; m_ctl[i] = '0; m_pre[i] = '0;
      end
      m_raw = '0; m_mask = '0; m_irq = 1'b0; m_rdata = '0;
    end else begin
      if (reg_re) m_rdata = model_read(reg_addr);
      evv = '0;
      for (int i = 0; i < 4; i++) begin
        logic w, run, tk, ld, bg, cw;
        logic [31:0] cur;
        w   = m_ctl[i][1];
        run = m_ctl[i][7];
        cur = fit(m_cnt[i], w);
        tk  = run && (m_ctl[i][3] ? (m_pre[i] == 8'hFF) :
                      m_ctl[i][2] ? (m_pre[i][3:0] == 4'hF) : 1'b1);
        ld  = reg_we && reg_addr[7:4] == 4'(i + 1) && reg_addr[3:2] == 2'd0;
        bg  = reg_we && reg_addr[7:4] == 4'(i + 1) && reg_addr[3:2] == 2'd3;
        cw  = reg_we && reg_addr[7:4] == 4'(i + 1) && reg_addr[3:2] == 2'd2;
        evv[i] = tk && cur == 0 && !ld;
        if (ld) m_cnt[i] = fit(reg_wdata, w);
        else if (tk) begin
          if (cur != 0)          m_cnt[i] = fit(cur - 1, w);
          else if (m_ctl[i][0])  m_cnt[i] = 0;
          else if (m_ctl[i][6])  m_cnt[i] = fit(m_rel[i], w);
          else                   m_cnt[i] = fit(32'hFFFF_FFFF, w);
        end
        if (ld || bg) m_rel[i] = reg_wdata;
        m_pre[i] = cw ? 8'h0 : run ? m_pre[i] + 1 : m_pre[i];
        if (cw) m_ctl[i] = reg_wdata[7:0] & 8'hCF;
        else if (evv[i] && m_ctl[i][0]) m_ctl[i][7] = 1'b0;
      end
      m_irq = |(m_raw & m_mask);
      m_raw = (m_raw & ~((reg_we && reg_addr[7:2] == 6'd3) ? reg_wdata[3:0] : 4'h0)) | evv;
      if (reg_we && reg_addr[7:2] == 6'd0) m_mask = reg_wdata[3:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R12: interrupt line compared on every cycle
  always @(negedge clk) if (live) chk("R12 irq", {31'h0, irq_o}, {31'h0, m_irq});

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    chk(tag, reg_rdata, m_rdata);
  endtask

  task automatic rd_lit(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string tag_for(input logic [7:0] a);
    if (a[7:4] == 0)  return (a[3:2] == 2'd2) ? "R12 masked" : "R11 raw/mask";
    if (a[7:4] > 4)   return "R2 unmapped";
    case (a[3:2])
      2'd1:    return "R5 value";
      2'd2:    return "R3 ctrl";
      default: return "R9 reload";
    endcase
  endfunction

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    live = 1'b1;
    // R1: reset state
    for (int a = 0; a < 80; a += 4) rd_lit("R1 reset", 8'(a), 32'h0);
    chk("R1 irq low", {31'h0, irq_o}, 32'h0);

    // R10: narrow load keeps low half only; load register keeps full word
    wr(8'h10, 32'h1234_5678);
    rd_lit("R10 value upper zero", 8'h14, 32'h0000_5678);
    rd_lit("R9 load readback", 8'h10, 32'h1234_5678);
    // R3: undefined control bits read zero
    wr(8'h18, 32'hFFFF_FF30);
    rd_lit("R3 ctrl bits", 8'h18, 32'h0);

    // R9: background write leaves count untouched
    wr(8'h20, 32'd7);
    wr(8'h2C, 32'd9);
    rd_lit("R9 bg no count change", 8'h24, 32'd7);
    rd_lit("R9 bg readback", 8'h2C, 32'd9);

    // R8: one-shot, wide, divide by 1
    wr(8'h30, 32'd3);
    wr(8'h38, 32'h83);
    idle(10);
    rd_lit("R8 run cleared", 8'h38, 32'h03);
    rd_lit("R8 stays zero", 8'h34, 32'h0);
    rd_lit("R5 raw bit2", 8'h04, 32'h4);
    // R11: clear with zero bits leaves raw, then clears it
    wr(8'h0C, 32'h0);
    rd_lit("R11 zero bits", 8'h04, 32'h4);
    wr(8'h0C, 32'h4);
    rd_lit("R11 cleared", 8'h04, 32'h0);

    // R7: free-running, narrow, from zero
    wr(8'h40, 32'h0);
    wr(8'h48, 32'h80);
    idle(1);
    rd("R7 narrow wrap", 8'h44);
    rd("R7 narrow wrap", 8'h44);

    // R6 / R9: periodic with background reload taking effect at wrap
    wr(8'h10, 32'd4);
    wr(8'h18, 32'hC2);
    wr(8'h1C, 32'd2);
    for (int k = 0; k < 12; k++) rd("R6 periodic value", 8'h14);
    // R12: mask and interrupt
    wr(8'h00, 32'hF);
    idle(3);
    rd("R12 masked", 8'h08);

    // R4: divide by 16 and by 256
    wr(8'h20, 32'd2);
    wr(8'h28, 32'hC6);
    for (int k = 0; k < 60; k++) rd("R4 div16", 8'h24);
    wr(8'h28, 32'hCA);
    for (int k = 0; k < 40; k++) begin idle(20); rd("R4 div256", 8'h24); end
    wr(8'h28, 32'h0);

    // constrained random mixed traffic
    for (int n = 0; n < 6000; n++) begin
      int op = $urandom_range(0, 9);
      int ch = $urandom_range(1, 4);
      case (op)
        0: wr(8'((ch << 4)), 32'($urandom_range(0, 40)) | ($urandom_range(0, 3) == 0 ? 32'h0001_0000 : 32'h0));
        1: wr(8'((ch << 4) | 12), 32'($urandom_range(0, 40)));
        2: wr(8'((ch << 4) | 8), 32'($urandom_range(0, 255)) | 32'h80);
        3: wr(8'h00, 32'($urandom_range(0, 15)));
        4: wr(8'h0C, 32'($urandom_range(0, 15)));
        5: if ($urandom_range(0, 7) == 0) wr(8'h58, 32'hFF);
           else idle($urandom_range(1, 6));
        default: begin
          logic [7:0] a = 8'($urandom_range(0, 21) * 4);
          rd(tag_for(a), a);
        end
      endcase
    end
    idle(2);
    summary();
  end
endmodule